// File: doc/BRIEF.md
# Circular Trace Capture Buffer

A trace sink that stores 32-bit trace words in an on-chip RAM used as a ring. An upstream source presents a word with a valid strobe and may raise a separate trigger strobe. Software reaches the block through a simple single-cycle register bus. Through it, software can:
- read the buffer size;
- move the read and write pointers;
- fetch or deposit words through auto-incrementing data ports;
- enable capture;
- set up how capture ends.

Capture can end in two ways. It can end a programmed number of words after a trigger, or it can end when a manual flush completes. Either way the block first pads the buffer with zero words up to the next four-word frame boundary, so a cleanly stopped buffer always ends on a frame edge. A wrap flag shows that every location holds captured data. In that case the oldest word is at the write pointer; otherwise valid data begins at address 0.

Top module: `tracebuf_sink`

## Requirements
- R1: After reset the size register (0x004) reads DEPTH; status (0x00C), control (0x020), read pointer (0x014), write pointer (0x018), trigger count (0x01C) and flush control (0x304) read 0; flush status (0x300) reads 0x2.
- R2: While control bit 0 is 1 and capture is not stopped, each valid trace word is stored at the write pointer, which then advances modulo DEPTH. While control bit 0 is 0, trace words are ignored.
- R3: A read of 0x010 returns the word at the read pointer and advances the read pointer modulo DEPTH; a write to 0x014 loads the read pointer.
- R4: A write to 0x024 stores the bus word at the write pointer and advances the write pointer modulo DEPTH.
- R5: Status bit 0 sets when the write pointer wraps from DEPTH-1 to 0, and clears when software writes the write pointer (0x018).
- R6: With flush control bit 13 set, a trigger during capture arms a countdown: exactly the trigger-count number of further words are stored, the count register drops by one per stored word, and later words are dropped. With bit 13 clear, triggers have no effect.
- R7: After a trigger stop the block writes zero words until the write pointer is a multiple of 4, then halts. While halted, flush status reads 0x2 (bit 1 stopped, bit 0 draining clear) and trace words are ignored.
- R8: Writing 1 to flush control bit 6 starts a manual flush. The bit reads 1 until the write pointer has been zero-padded to a multiple of 4, then clears itself. Writing 0 to the bit does not cancel a flush.
- R9: With flush control bit 12 set, a completed flush halts capture. With bit 12 clear, capture resumes after the flush.
- R10: A write to control sets the capture enable from bit 0 and clears a halt. Flush status bit 1 reads 1 whenever capture is disabled or halted. Flush control bit 0 is stored and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| tr_valid | input | 1 | Trace word valid |
| tr_data | input | 32 | Trace word |
| tr_trig | input | 1 | Trigger strobe |

## Verification
Most faults in the pointers or in the sequencer show up as a wrong write-pointer value at the next register read. A missing or extra pad word, or a trigger countdown that is off by one, shifts the write pointer off the expected frame boundary. It also leaves a non-zero word where a zero pad word should be when the buffer is read back. A stuck flush or stop state shows within a few cycles: the self-clearing flush bit keeps reading 1, or flush status fails to report the stop. A wrong wrap decision shows in status bit 0 on the access right after the fourth word that crosses the top of the RAM.

// File: rtl/tracebuf_pkg.sv
package tracebuf_pkg;

  localparam logic [11:0] TB_OFF_DEPTH  = 12'h004;
  localparam logic [11:0] TB_OFF_STAT   = 12'h00C;
  localparam logic [11:0] TB_OFF_RDAT   = 12'h010;
  localparam logic [11:0] TB_OFF_RPTR   = 12'h014;
  localparam logic [11:0] TB_OFF_WPTR   = 12'h018;
  localparam logic [11:0] TB_OFF_TRG    = 12'h01C;
  localparam logic [11:0] TB_OFF_CTL    = 12'h020;
  localparam logic [11:0] TB_OFF_WDAT   = 12'h024;
  localparam logic [11:0] TB_OFF_FSTAT  = 12'h300;
  localparam logic [11:0] TB_OFF_FCTL   = 12'h304;

  localparam int TB_FC_FMT   = 0;
  localparam int TB_FC_FLUSH = 6;
  localparam int TB_FC_SFL   = 12;
  localparam int TB_FC_STRG  = 13;

  typedef enum logic [1:0] {
    TB_RUN   = 2'd0,
    TB_FLUSH = 2'd1,
    TB_TSTOP = 2'd2,
    TB_HALT  = 2'd3
  } tb_state_e;

endpackage

// File: rtl/tracebuf_ram.sv
module tracebuf_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/tracebuf_regs.sv
module tracebuf_regs
  import tracebuf_pkg::*;
#(
  parameter int DW     = 32,
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 12,
  parameter int TRG_W  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [DW-1:0]     bus_rdata,
  output logic              wr_ctl,
  output logic              wr_fctl,
  output logic              wr_trg,
  output logic              wr_wptr,
  output logic              wr_rptr,
  output logic              wr_wdat,
  output logic              rd_rdat,
  input  logic              cap_en,
  input  logic              fmt_en,
  input  logic              flush_man,
  input  logic              stop_on_flush,
  input  logic              stop_on_trig,
  input  logic              full,
  input  logic              halted,
  input  logic              draining,
  input  logic [AW-1:0]     wptr,
  input  logic [AW-1:0]     rptr,
  input  logic [TRG_W-1:0]  trg_cnt,
  input  logic [DW-1:0]     ram_rdata
);

  logic wr_s;
  logic rd_s;
  logic [DW-1:0] fctl_word;

  assign wr_s = bus_en & bus_we;
  assign rd_s = bus_en & ~bus_we;

  assign wr_ctl  = wr_s && (bus_addr == ADDR_W'(TB_OFF_CTL));
  assign wr_fctl = wr_s && (bus_addr == ADDR_W'(TB_OFF_FCTL));
  assign wr_trg  = wr_s && (bus_addr == ADDR_W'(TB_OFF_TRG));
  assign wr_wptr = wr_s && (bus_addr == ADDR_W'(TB_OFF_WPTR));
  assign wr_rptr = wr_s && (bus_addr == ADDR_W'(TB_OFF_RPTR));
  assign wr_wdat = wr_s && (bus_addr == ADDR_W'(TB_OFF_WDAT));
  assign rd_rdat = rd_s && (bus_addr == ADDR_W'(TB_OFF_RDAT));

  always_comb begin
    fctl_word             = '0;
    fctl_word[TB_FC_FMT]   = fmt_en;
    fctl_word[TB_FC_FLUSH] = flush_man;
    fctl_word[TB_FC_SFL]   = stop_on_flush;
    fctl_word[TB_FC_STRG]  = stop_on_trig;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_s) begin
      unique case (bus_addr)
        ADDR_W'(TB_OFF_DEPTH): bus_rdata = DW'(DEPTH);
        ADDR_W'(TB_OFF_STAT):  bus_rdata = {{(DW-1){1'b0}}, full};
        ADDR_W'(TB_OFF_RDAT):  bus_rdata = ram_rdata;
        ADDR_W'(TB_OFF_RPTR):  bus_rdata = {{(DW-AW){1'b0}}, rptr};
        ADDR_W'(TB_OFF_WPTR):  bus_rdata = {{(DW-AW){1'b0}}, wptr};
        ADDR_W'(TB_OFF_TRG):   bus_rdata = {{(DW-TRG_W){1'b0}}, trg_cnt};
        ADDR_W'(TB_OFF_CTL):   bus_rdata = {{(DW-1){1'b0}}, cap_en};
        ADDR_W'(TB_OFF_FSTAT): bus_rdata = {{(DW-2){1'b0}}, (halted | ~cap_en), draining};
        ADDR_W'(TB_OFF_FCTL):  bus_rdata = fctl_word;
        default:               bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/tracebuf_seq.sv
module tracebuf_seq
  import tracebuf_pkg::*;
#(
  parameter int DW          = 32,
  parameter int DEPTH       = 64,
  parameter int FRAME_WORDS = 4,
  parameter int TRG_W       = 16,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tr_valid,
  input  logic [DW-1:0]    tr_data,
  input  logic             tr_trig,
  input  logic             wr_ctl,
  input  logic             wr_fctl,
  input  logic             wr_trg,
  input  logic             wr_wptr,
  input  logic             wr_rptr,
  input  logic             wr_wdat,
  input  logic             rd_rdat,
  input  logic [DW-1:0]    bus_wdata,
  output logic             cap_en,
  output logic             fmt_en,
  output logic             flush_man,
  output logic             stop_on_flush,
  output logic             stop_on_trig,
  output logic             full,
  output logic             halted,
  output logic             draining,
  output logic [AW-1:0]    wptr,
  output logic [AW-1:0]    rptr,
  output logic [TRG_W-1:0] trg_cnt,
  output logic             ram_we,
  output logic [AW-1:0]    ram_waddr,
  output logic [DW-1:0]    ram_wdata
);

  localparam int FB = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  tb_state_e        st_q, st_d;
  logic             cap_en_d, fmt_en_d, flush_d, sfl_d, strg_d;
  logic             full_d, armed_q, armed_d;
  logic [AW-1:0]    wptr_d, rptr_d;
  logic [TRG_W-1:0] trg_d;

  logic bus_owns_wp;
  logic misaligned;
  logic pad_need;
  logic pad_we;
  logic cap_we;
  logic trg_expired;
  logic flush_done;
  logic unused_bits;

  assign unused_bits = ^{bus_wdata[DW-1:TB_FC_STRG+1]};

  function automatic logic [AW-1:0] ring_inc(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign bus_owns_wp = wr_wdat | wr_wptr;
  assign misaligned  = (wptr[FB-1:0] != '0);
  assign pad_need    = cap_en & misaligned;
  assign trg_expired = armed_q & stop_on_trig & (trg_cnt == '0);

  assign pad_we = pad_need & ((st_q == TB_FLUSH) | (st_q == TB_TSTOP)) & ~bus_owns_wp;
  assign cap_we = tr_valid & cap_en & (st_q == TB_RUN) & ~trg_expired & ~bus_owns_wp;

  assign ram_we    = wr_wdat | pad_we | cap_we;
  assign ram_waddr = wptr;
  assign ram_wdata = wr_wdat ? bus_wdata : (pad_we ? '0 : tr_data);

  assign flush_done = flush_man & (((st_q == TB_FLUSH) & ~pad_need) | (st_q == TB_HALT));

  assign halted   = (st_q == TB_HALT);
  assign draining = (st_q == TB_FLUSH) | (st_q == TB_TSTOP);

  // pointer, flag and counter next state
  always_comb begin
    wptr_d = wptr;
    if (wr_wptr) begin
      wptr_d = bus_wdata[AW-1:0];
    end else if (ram_we) begin
      wptr_d = ring_inc(wptr);
    end

    full_d = full;
    if (wr_wptr) begin
      full_d = 1'b0;
    end else if (ram_we && (wptr == LAST)) begin
      full_d = 1'b1;
    end

    rptr_d = rptr;
    if (wr_rptr) begin
      rptr_d = bus_wdata[AW-1:0];
    end else if (rd_rdat) begin
      rptr_d = ring_inc(rptr);
    end

    trg_d = trg_cnt;
    if (wr_trg) begin
      trg_d = bus_wdata[TRG_W-1:0];
    end else if (cap_we && armed_q && (trg_cnt != '0)) begin
      trg_d = trg_cnt - TRG_W'(1);
    end

    armed_d = armed_q;
    if (wr_ctl) begin
      armed_d = 1'b0;
    end else if ((st_q == TB_RUN) && cap_en && tr_trig && stop_on_trig) begin
      armed_d = 1'b1;
    end
  end

  // configuration next state
  always_comb begin
    cap_en_d = wr_ctl  ? bus_wdata[0]           : cap_en;
    fmt_en_d = wr_fctl ? bus_wdata[TB_FC_FMT]   : fmt_en;
    sfl_d    = wr_fctl ? bus_wdata[TB_FC_SFL]   : stop_on_flush;
    strg_d   = wr_fctl ? bus_wdata[TB_FC_STRG]  : stop_on_trig;
    if (wr_fctl && bus_wdata[TB_FC_FLUSH]) begin
      flush_d = 1'b1;
    end else if (flush_done) begin
      flush_d = 1'b0;
    end else begin
      flush_d = flush_man;
    end
  end

  // sequencer next state
  always_comb begin
    st_d = st_q;
    if (wr_ctl) begin
      st_d = TB_RUN;
    end else begin
      unique case (st_q)
        TB_RUN: begin
          if (flush_man) begin
            st_d = TB_FLUSH;
          end else if (trg_expired) begin
            st_d = TB_TSTOP;
          end
        end
        TB_FLUSH: begin
          if (!pad_need) begin
            st_d = stop_on_flush ? TB_HALT : TB_RUN;
          end
        end
        TB_TSTOP: begin
          if (!pad_need) begin
            st_d = TB_HALT;
          end
        end
        default: st_d = TB_HALT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= TB_RUN;
      cap_en        <= 1'b0;
      fmt_en        <= 1'b0;
      flush_man     <= 1'b0;
      stop_on_flush <= 1'b0;
      stop_on_trig  <= 1'b0;
      full          <= 1'b0;
      armed_q       <= 1'b0;
      wptr          <= '0;
      rptr          <= '0;
      trg_cnt       <= '0;
    end else begin
      st_q          <= st_d;
      cap_en        <= cap_en_d;
      fmt_en        <= fmt_en_d;
      flush_man     <= flush_d;
      stop_on_flush <= sfl_d;
      stop_on_trig  <= strg_d;
      full          <= full_d;
      armed_q       <= armed_d;
      wptr          <= wptr_d;
      rptr          <= rptr_d;
      trg_cnt       <= trg_d;
    end
  end

endmodule

// File: rtl/tracebuf_sink.sv
module tracebuf_sink #(
  parameter int DW          = 32,
  parameter int DEPTH       = 64,
  parameter int FRAME_WORDS = 4,
  parameter int TRG_W       = 16,
  parameter int ADDR_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              tr_valid,
  input  logic [DW-1:0]     tr_data,
  input  logic              tr_trig
);

  localparam int AW = $clog2(DEPTH);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             wr_ctl, wr_fctl, wr_trg, wr_wptr, wr_rptr, wr_wdat, rd_rdat;
  logic             cap_en, fmt_en, flush_man, stop_on_flush, stop_on_trig;
  logic             full, halted, draining;
  logic [AW-1:0]    wptr, rptr;
  logic [TRG_W-1:0] trg_cnt;
  logic             ram_we;
  logic [AW-1:0]    ram_waddr;
  logic [DW-1:0]    ram_wdata, ram_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  tracebuf_regs #(
    .DW(DW), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .TRG_W(TRG_W)
  ) u_regs (
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .wr_ctl(wr_ctl), .wr_fctl(wr_fctl), .wr_trg(wr_trg), .wr_wptr(wr_wptr),
    .wr_rptr(wr_rptr), .wr_wdat(wr_wdat), .rd_rdat(rd_rdat),
    .cap_en(cap_en), .fmt_en(fmt_en), .flush_man(flush_man),
    .stop_on_flush(stop_on_flush), .stop_on_trig(stop_on_trig),
    .full(full), .halted(halted), .draining(draining),
    .wptr(wptr), .rptr(rptr), .trg_cnt(trg_cnt), .ram_rdata(ram_rdata)
  );

  tracebuf_seq #(
    .DW(DW), .DEPTH(DEPTH), .FRAME_WORDS(FRAME_WORDS), .TRG_W(TRG_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .tr_valid(tr_valid), .tr_data(tr_data), .tr_trig(tr_trig),
    .wr_ctl(wr_ctl), .wr_fctl(wr_fctl), .wr_trg(wr_trg), .wr_wptr(wr_wptr),
    .wr_rptr(wr_rptr), .wr_wdat(wr_wdat), .rd_rdat(rd_rdat), .bus_wdata(bus_wdata),
    .cap_en(cap_en), .fmt_en(fmt_en), .flush_man(flush_man),
    .stop_on_flush(stop_on_flush), .stop_on_trig(stop_on_trig),
    .full(full), .halted(halted), .draining(draining),
    .wptr(wptr), .rptr(rptr), .trg_cnt(trg_cnt),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  tracebuf_ram #(
    .DW(DW), .DEPTH(DEPTH)
  ) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(rptr), .rdata(ram_rdata)
  );

endmodule

// File: rtl/tracebuf_sink_chk.sv
module tracebuf_sink_chk
  import tracebuf_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int FRAME_WORDS = 4,
  parameter int ADDR_W      = 12,
  localparam int AW         = $clog2(DEPTH),
  localparam int FB         = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              cap_en,
  input logic              halted,
  input logic              full,
  input logic              flush_man,
  input logic [AW-1:0]     wptr,
  input logic [AW-1:0]     rptr
);

  // R2
  capture_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !bus_en) |=> $stable(wptr));

  // R3
  rdat_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == ADDR_W'(TB_OFF_RDAT)) |=>
      (rptr == (($past(rptr) == AW'(DEPTH - 1)) ? '0 : $past(rptr) + AW'(1))));

  // R5
  full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> ($past(wptr) == AW'(DEPTH - 1)));

  // R5
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == ADDR_W'(TB_OFF_WPTR)) |=> !full);

  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !bus_en) |=> $stable(wptr));

  // R8
  flush_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_man) |-> ((wptr[FB-1:0] == '0) || !$past(cap_en) ||
                          $past(halted) || $past(bus_en)));

endmodule

bind tracebuf_sink tracebuf_sink_chk #(
  .DEPTH(DEPTH), .FRAME_WORDS(FRAME_WORDS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .cap_en(cap_en), .halted(halted), .full(full),
  .flush_man(flush_man), .wptr(wptr), .rptr(rptr)
);

// File: tb/tracebuf_sink_bench.sv
`timescale 1ns/1ps
module tracebuf_sink_bench;

  localparam logic [11:0] A_DEPTH = 12'h004;
  localparam logic [11:0] A_STAT  = 12'h00C;
  localparam logic [11:0] A_RDAT  = 12'h010;
  localparam logic [11:0] A_RPTR  = 12'h014;
  localparam logic [11:0] A_WPTR  = 12'h018;
  localparam logic [11:0] A_TRG   = 12'h01C;
  localparam logic [11:0] A_CTL   = 12'h020;
  localparam logic [11:0] A_WDAT  = 12'h024;
  localparam logic [11:0] A_FSTAT = 12'h300;
  localparam logic [11:0] A_FCTL  = 12'h304;

  logic        clk;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        tr_valid, tr_trig;
  logic [31:0] tr_data;

  int n_tests;
  int n_fail;
  bit done;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  tracebuf_sink u_tracebuf_sink (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tr_valid(tr_valid), .tr_data(tr_data), .tr_trig(tr_trig)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor: compare each read against the expected queue
  always @(negedge clk) begin
    if (rst_n && bus_en && !bus_we) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read: actual %08h expected none", bus_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s addr %03h: actual %08h expected %08h", t, bus_addr, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_en = 1'b0;
  endtask

  task automatic burst(input logic [31:0] base, input int n, input bit trig_first);
    for (int i = 0; i < n; i++) begin
      tr_valid = 1'b1; tr_data = base + 32'(i); tr_trig = trig_first && (i == 0);
      @(posedge clk); #1;
    end
    tr_valid = 1'b0; tr_trig = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    bus_en = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    tr_valid = 0; tr_data = '0; tr_trig = 0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(A_DEPTH, 32'd64, "R1");
    rd(A_STAT,  32'h0, "R1");
    rd(A_CTL,   32'h0, "R1");
    rd(A_RPTR,  32'h0, "R1");
    rd(A_WPTR,  32'h0, "R1");
    rd(A_TRG,   32'h0, "R1");
    rd(A_FCTL,  32'h0, "R1");
    rd(A_FSTAT, 32'h2, "R1");

    // R2 words ignored while disabled, then stored
    burst(32'hDEAD_0000, 3, 1'b0);
    rd(A_WPTR, 32'h0, "R2");
    wr(A_CTL, 32'h1);
    rd(A_CTL, 32'h1, "R10");
    burst(32'hA000_0000, 8, 1'b0);
    rd(A_WPTR, 32'd8, "R2");
    rd(A_FSTAT, 32'h0, "R10");

    // R3 read port
    wr(A_RPTR, 32'h0);
    for (int i = 0; i < 8; i++) rd(A_RDAT, 32'hA000_0000 + 32'(i), "R3");
    rd(A_RPTR, 32'd8, "R3");

    // R4 write port, R5 wrap via bus, R3 read wrap
    wr(A_WPTR, 32'd62);
    wr(A_WDAT, 32'h11);
    wr(A_WDAT, 32'h22);
    rd(A_WPTR, 32'h0, "R4");
    rd(A_STAT, 32'h1, "R5");
    wr(A_RPTR, 32'd62);
    rd(A_RDAT, 32'h11, "R4");
    rd(A_RDAT, 32'h22, "R4");
    rd(A_RDAT, 32'hA000_0000, "R3");
    rd(A_RPTR, 32'd1, "R3");
    wr(A_WPTR, 32'h0);
    rd(A_STAT, 32'h0, "R5");

    // R5 wrap via capture
    wr(A_WPTR, 32'd60);
    burst(32'hB000_0000, 4, 1'b0);
    rd(A_WPTR, 32'h0, "R5");
    rd(A_STAT, 32'h1, "R5");

    // R6 / R7 stop on trigger with five post-trigger words
    wr(A_WPTR, 32'h0);
    wr(A_TRG, 32'd5);
    rd(A_TRG, 32'd5, "R6");
    wr(A_FCTL, 32'h2001);
    rd(A_FCTL, 32'h2001, "R10");
    burst(32'hC000_0000, 8, 1'b1);
    idle(6);
    rd(A_WPTR, 32'd8, "R7");
    rd(A_TRG, 32'h0, "R6");
    rd(A_FSTAT, 32'h2, "R7");
    wr(A_RPTR, 32'h0);
    for (int i = 0; i < 6; i++) rd(A_RDAT, 32'hC000_0000 + 32'(i), "R6");
    rd(A_RDAT, 32'h0, "R7");
    rd(A_RDAT, 32'h0, "R7");
    burst(32'hD000_0000, 2, 1'b0);
    rd(A_WPTR, 32'd8, "R7");

    // R6 trigger without stop-on-trigger, R10 restart
    wr(A_FCTL, 32'h0);
    wr(A_CTL, 32'h1);
    rd(A_FSTAT, 32'h0, "R10");
    burst(32'hE000_0000, 3, 1'b1);
    idle(3);
    rd(A_WPTR, 32'd11, "R6");

    // R8 manual flush, capture continues (R9)
    wr(A_FCTL, 32'h40);
    rd(A_FCTL, 32'h40, "R8");
    idle(4);
    rd(A_FCTL, 32'h0, "R8");
    rd(A_WPTR, 32'd12, "R8");
    wr(A_RPTR, 32'd10);
    rd(A_RDAT, 32'hE000_0002, "R8");
    rd(A_RDAT, 32'h0, "R8");
    burst(32'hF000_0000, 1, 1'b0);
    rd(A_WPTR, 32'd13, "R9");

    // R9 stop on flush
    wr(A_FCTL, 32'h1040);
    idle(6);
    rd(A_WPTR, 32'd16, "R9");
    rd(A_FSTAT, 32'h2, "R9");
    rd(A_FCTL, 32'h1000, "R9");
    burst(32'hF100_0000, 1, 1'b0);
    rd(A_WPTR, 32'd16, "R9");

    // R10 disable and restart
    wr(A_CTL, 32'h0);
    rd(A_CTL, 32'h0, "R10");
    rd(A_FSTAT, 32'h2, "R10");
    wr(A_CTL, 32'h1);
    rd(A_FSTAT, 32'h0, "R10");
    burst(32'hF200_0000, 1, 1'b0);
    rd(A_WPTR, 32'd17, "R10");

    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule